// File: doc/BRIEF.md
# Chunked Hamming ECC Generator and Checker

This block sits on the byte data path of a NAND flash controller. It computes a single-error-correcting Hamming code over each fixed chunk of 256 bytes, in whichever direction the bytes flow. Each accepted byte updates a running parity word. When the last byte of a chunk is accepted, the finished word is copied into a holding register and a one-cycle strobe tells the surrounding logic that it can capture the word. A 512-byte page therefore produces two words and a 2048-byte page produces eight.

A clear input restarts the current chunk. An enable input decides whether offered bytes take part at all. A combinational formatter turns the held word into the three bytes that go into the spare area. On a small-page device with a 16-byte spare area, the six bytes of the two chunks are placed at spare offsets 10 to 15.

A separate combinational checking stage takes a stored code and a recomputed code, both in spare-area form, and classifies the difference between them. The result is one of four outcomes: clean, a correctable data bit (with the byte address and bit index of the bad bit), a flipped code bit, or uncorrectable.

Top module: `nand_chunk_ecc`

## Requirements
- R1: The position counter advances on each accepted byte (`byte_vld` and `ecc_en` both high). On the 256th accepted byte after reset, after a clear or after the previous chunk ended, `ecc_word` takes the finished code at that clock edge. `ecc_done` is high for exactly the following cycle. The next accepted byte starts a new chunk from zero.
- R2: In `ecc_word`, bit 2k+1 is the XOR of every data bit in bytes whose chunk address has bit k set, for k = 0..7. Bit 2k is the same XOR over bytes whose address has bit k clear. Bit 16+2j+1 is the XOR, over the chunk, of the data bits whose index has bit j set, and bit 16+2j covers those whose index has bit j clear, for j = 0..2. Bits 23:22 are zero.
- R3: A byte offered while `ecc_en` is low does not change the parity, the chunk position or `ecc_done`.
- R4: `ecc_clr` high zeroes the parity and the chunk position at the clock edge. It takes priority over a byte offered in the same cycle, and it leaves `ecc_word` unchanged.
- R5: `code_bytes` equals the bitwise NOT of `ecc_word` shifted left by two, kept to 24 bits. Its bits 23:16 are the first spare byte, 15:8 the second and 7:0 the third.
- R6: When `chk_stored` equals `chk_calc`, `err_kind` is 0 (clean).
- R7: When each of the 11 bit pairs (2+2p, 3+2p), p = 0..10, of `chk_stored ^ chk_calc` has exactly one bit set and no other bit is set, `err_kind` is 1. In that case `err_byte` bit k is syndrome bit 3+2k, and `err_bit` bit j is syndrome bit 19+2j.
- R8: When the syndrome has exactly one bit set, `err_kind` is 2 (the error is in the code itself).
- R9: Any other nonzero syndrome gives `err_kind` 3 (uncorrectable).
- R10: After reset, `ecc_word` is zero, `ecc_done` is low and the chunk position is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_clr | input | 1 | Restart the current chunk |
| ecc_en | input | 1 | Allow bytes to be accumulated |
| byte_vld | input | 1 | A data byte is present this cycle |
| byte_dat | input | 8 | Data byte |
| ecc_word | output | 24 | Raw code of the last finished chunk |
| ecc_done | output | 1 | One-cycle strobe after a chunk ends |
| code_bytes | output | 24 | Spare-area form of `ecc_word` |
| chk_stored | input | 24 | Code read back from the spare area |
| chk_calc | input | 24 | Code recomputed from the data read |
| err_kind | output | 2 | 0 clean, 1 correctable, 2 code bit, 3 uncorrectable |
| err_byte | output | 8 | Byte address of the bad bit (when `err_kind` is 1) |
| err_bit | output | 3 | Bit index of the bad bit (when `err_kind` is 1) |

## Verification
The bench aims at the chunk boundary. A chunk that ends one byte early or one byte late shows up as a strobe in the wrong cycle, and from then on every later chunk's word is wrong too. Several other stimuli probe the position counter and the parity:
- bytes offered while accumulation is disabled;
- a clear that arrives together with a byte;
- single hot bytes at address 0.

A wrong even/odd pairing or a leaked byte would change the word or delay the strobe. For the checking stage, data errors are placed at the first byte, the last byte and an interior byte, at the lowest and highest bit index. A swapped pair or a misread odd bit would give the wrong location or the wrong class. Single code-bit and multi-bit syndromes confirm that the four classes are kept apart.

// File: rtl/nce_pkg.sv
`timescale 1ns/1ps
package nce_pkg;
   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_FIXED   = 2'd1,
      ERR_IN_CODE = 2'd2,
      ERR_FATAL   = 2'd3
   } err_kind_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/nce_accum.sv
`timescale 1ns/1ps
module nce_accum #(
   parameter int CHUNK_BYTES = 256,
   parameter int DATA_W      = 8,
   localparam int ADDR_W     = $clog2(CHUNK_BYTES),
   localparam int BIT_W      = $clog2(DATA_W),
   localparam int RAW_W      = 2 * (ADDR_W + BIT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              vld,
   input  logic [DATA_W-1:0] dat,
   output logic [RAW_W-1:0]  word_q,
   output logic              done_q
);
   localparam logic [ADDR_W-1:0] LAST_POS = ADDR_W'(CHUNK_BYTES - 1);

   logic [ADDR_W-1:0] pos;
   logic [RAW_W-1:0]  acc;
   logic [RAW_W-1:0]  delta;
   logic [RAW_W-1:0]  acc_nxt;
   logic              take;
   logic              byte_par;

   assign take     = vld & en;
   assign byte_par = ^dat;

   // Line parity: byte parity steered by each address bit
   for (genvar k = 0; k < ADDR_W; k++) begin : g_line
      assign delta[2*k]   = byte_par & ~pos[k];
      assign delta[2*k+1] = byte_par &  pos[k];
   end

   // Column parity: data bits split by each bit-index bit
   for (genvar j = 0; j < BIT_W; j++) begin : g_col
      logic [DATA_W-1:0] sel_lo;
      logic [DATA_W-1:0] sel_hi;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         if (((i >> j) & 1) == 0) begin : g_lo
            assign sel_lo[i] = dat[i];
            assign sel_hi[i] = 1'b0;
         end else begin : g_hi
            assign sel_lo[i] = 1'b0;
            assign sel_hi[i] = dat[i];
         end
      end
      assign delta[2*ADDR_W+2*j]   = ^sel_lo;
      assign delta[2*ADDR_W+2*j+1] = ^sel_hi;
   end

   assign acc_nxt = acc ^ delta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos    <= '0;
         acc    <= '0;
         word_q <= '0;
         done_q <= 1'b0;
      end else if (clr) begin
         pos    <= '0;
         acc    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (take) begin
            pos <= pos + 1'b1;
            if (pos == LAST_POS) begin
               word_q <= acc_nxt;
               done_q <= 1'b1;
               acc    <= '0;
            end else begin
               acc <= acc_nxt;
            end
         end
      end
   end
endmodule

// File: rtl/nce_format.sv
`timescale 1ns/1ps
module nce_format #(
   parameter int RAW_W  = 22,
   parameter int ECC_W  = 24,
   parameter bit INVERT = 1'b1
) (
   input  logic [RAW_W-1:0] raw,
   output logic [ECC_W-1:0] code
);
   logic [ECC_W-1:0] shifted;

   assign shifted = {{(ECC_W-RAW_W){1'b0}}, raw} << 2;

   if (INVERT) begin : g_inv
      assign code = ~shifted;
   end else begin : g_true
      assign code = shifted;
   end
endmodule

// File: rtl/nce_syndrome.sv
`timescale 1ns/1ps
module nce_syndrome
   import nce_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BIT_W  = 3,
   parameter int ECC_W  = 24,
   localparam int NPAIR = ADDR_W + BIT_W
) (
   input  logic [ECC_W-1:0]  stored,
   input  logic [ECC_W-1:0]  calc,
   output err_kind_e         kind,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [BIT_W-1:0]  bit_idx
);
   logic [ECC_W-1:0] syn;
   logic [NPAIR-1:0] pair_diff;
   logic [NPAIR-1:0] odd_b;
   int               ones;

   assign syn = stored ^ calc;

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      assign pair_diff[p] = syn[2+2*p] ^ syn[3+2*p];
      assign odd_b[p]     = syn[3+2*p];
   end

   always_comb begin
      ones      = $countones(syn);
      byte_addr = '0;
      bit_idx   = '0;
      if (syn == '0) begin
         kind = ERR_NONE;
      end else if ((&pair_diff) && (ones == NPAIR)) begin
         kind      = ERR_FIXED;
         byte_addr = odd_b[ADDR_W-1:0];
         bit_idx   = odd_b[NPAIR-1:ADDR_W];
      end else if (ones == 1) begin
         kind = ERR_IN_CODE;
      end else begin
         kind = ERR_FATAL;
      end
   end
endmodule

// File: rtl/nand_chunk_ecc.sv
`timescale 1ns/1ps
module nand_chunk_ecc
   import nce_pkg::*;
#(
   parameter int  CHUNK_BYTES = 256,
   parameter int  DATA_W      = 8,
   parameter int  ECC_W       = 24,
   parameter bit  INVERT_CODE = 1'b1,
   localparam int ADDR_W      = $clog2(CHUNK_BYTES),
   localparam int BIT_W       = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ecc_clr,
   input  logic              ecc_en,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_dat,
   output logic [ECC_W-1:0]  ecc_word,
   output logic              ecc_done,
   output logic [ECC_W-1:0]  code_bytes,
   input  logic [ECC_W-1:0]  chk_stored,
   input  logic [ECC_W-1:0]  chk_calc,
   output logic [1:0]        err_kind,
   output logic [ADDR_W-1:0] err_byte,
   output logic [BIT_W-1:0]  err_bit
);
   localparam int RAW_W = 2 * (ADDR_W + BIT_W);

   if (!is_pow2(CHUNK_BYTES)) begin : g_bad_chunk
      $error("CHUNK_BYTES must be a power of two of at least 2");
   end
   if (!is_pow2(DATA_W)) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 2");
   end
   if (ECC_W < RAW_W + 2) begin : g_bad_ecc
      $error("ECC_W too narrow for the shifted code");
   end

   logic [RAW_W-1:0] raw_word;
   err_kind_e        kind;

   nce_accum #(
      .CHUNK_BYTES(CHUNK_BYTES),
      .DATA_W     (DATA_W)
   ) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ecc_clr),
      .en    (ecc_en),
      .vld   (byte_vld),
      .dat   (byte_dat),
      .word_q(raw_word),
      .done_q(ecc_done)
   );

   assign ecc_word = {{(ECC_W-RAW_W){1'b0}}, raw_word};

   nce_format #(
      .RAW_W (RAW_W),
      .ECC_W (ECC_W),
      .INVERT(INVERT_CODE)
   ) u_format (
      .raw (raw_word),
      .code(code_bytes)
   );

   nce_syndrome #(
      .ADDR_W(ADDR_W),
      .BIT_W (BIT_W),
      .ECC_W (ECC_W)
   ) u_syn (
      .stored   (chk_stored),
      .calc     (chk_calc),
      .kind     (kind),
      .byte_addr(err_byte),
      .bit_idx  (err_bit)
   );

   assign err_kind = kind;
endmodule

// File: rtl/nand_chunk_ecc_chk.sv
`timescale 1ns/1ps
module nand_chunk_ecc_chk #(
   parameter int ADDR_W = 8,
   parameter int BIT_W  = 3,
   parameter int ECC_W  = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ecc_clr,
   input logic             ecc_en,
   input logic [ECC_W-1:0] ecc_word,
   input logic             ecc_done,
   input logic [ECC_W-1:0] code_bytes,
   input logic [ECC_W-1:0] chk_stored,
   input logic [ECC_W-1:0] chk_calc,
   input logic [1:0]       err_kind
);
   a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_done |=> !ecc_done);

   a_r1_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ecc_done |-> $stable(ecc_word));

   a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ecc_en |=> !ecc_done);

   a_r4_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_clr |=> (!ecc_done && $stable(ecc_word)));

   a_r5_code_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ecc_word) |-> $stable(code_bytes));

   a_r6_match_none: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_stored == chk_calc) |-> (err_kind == 2'd0));

   a_r7_fix_weight: assert property (@(posedge clk) disable iff (!rst_n)
      (err_kind == 2'd1) |-> ($countones(chk_stored ^ chk_calc) == ADDR_W + BIT_W));

   a_r8_lone_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(chk_stored ^ chk_calc) == 1) |-> (err_kind == 2'd2));
endmodule

bind nand_chunk_ecc nand_chunk_ecc_chk #(
   .ADDR_W(ADDR_W),
   .BIT_W (BIT_W),
   .ECC_W (ECC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ecc_clr   (ecc_clr),
   .ecc_en    (ecc_en),
   .ecc_word  (ecc_word),
   .ecc_done  (ecc_done),
   .code_bytes(code_bytes),
   .chk_stored(chk_stored),
   .chk_calc  (chk_calc),
   .err_kind  (err_kind)
);

// File: tb/nand_chunk_ecc_tb.sv
`timescale 1ns/1ps
module nand_chunk_ecc_tb;
   logic        clk = 1'b0;
   logic        rst_n, clr, en, vld;
   logic [7:0]  dat;
   logic [23:0] ecc_word, code_bytes, stored, calc;
   logic        ecc_done;
   logic [1:0]  err_kind;
   logic [7:0]  err_byte;
   logic [2:0]  err_bit;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [7:0]  mem [256];
   int          cnt;
   logic [23:0] exp_word;
   logic        exp_done;

   always #2.5 clk = ~clk;

   nand_chunk_ecc u_dut (
      .clk(clk), .rst_n(rst_n), .ecc_clr(clr), .ecc_en(en),
      .byte_vld(vld), .byte_dat(dat), .ecc_word(ecc_word),
      .ecc_done(ecc_done), .code_bytes(code_bytes),
      .chk_stored(stored), .chk_calc(calc), .err_kind(err_kind),
      .err_byte(err_byte), .err_bit(err_bit)
   );

   function automatic logic [23:0] ref_of(input logic [7:0] a [256]);
      logic [23:0] w = '0;
      for (int ad = 0; ad < 256; ad++)
         for (int b = 0; b < 8; b++)
            if (a[ad][b]) begin
               for (int k = 0; k < 8; k++) w[2*k + ((ad >> k) & 1)] ^= 1'b1;
               for (int j = 0; j < 3; j++) w[16 + 2*j + ((b >> j) & 1)] ^= 1'b1;
            end
      return w;
   endfunction

   function automatic logic [23:0] code_of(input logic [23:0] w);
      return ~{w[21:0], 2'b00};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Called at a falling edge; applies inputs, runs one clock, compares.
   task automatic step(input string tag, input logic v, input logic [7:0] d,
                       input logic e, input logic c);
      vld = v; dat = d; en = e; clr = c;
      @(posedge clk);
      exp_done = 1'b0;
      if (c) cnt = 0;
      else if (v && e) begin
         mem[cnt] = d;
         cnt++;
         if (cnt == 256) begin
            exp_word = ref_of(mem);
            exp_done = 1'b1;
            cnt = 0;
         end
      end
      @(negedge clk);
      chk({tag, " word"}, {8'h0, ecc_word}, {8'h0, exp_word});
      chk({tag, " done"}, {31'h0, ecc_done}, {31'h0, exp_done});
      chk("R5 code", {8'h0, code_bytes}, {8'h0, code_of(exp_word)});
   endtask

   task automatic feed(input string tag, input int n, input int mode);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         case (mode)
            0: b = 8'h00;
            1: b = 8'(i * 37 + 5);
            default: b = 8'($urandom);
         endcase
         step(tag, 1'b1, b, 1'b1, 1'b0);
      end
   endtask

   task automatic syn_chk(input string tag, input logic [23:0] s, input logic [23:0] c,
                          input logic [1:0] k, input logic [7:0] ba, input logic [2:0] bi);
      stored = s; calc = c;
      #1;
      chk({tag, " kind"}, {30'h0, err_kind}, {30'h0, k});
      if (k == 2'd1) begin
         chk({tag, " byte"}, {24'h0, err_byte}, {24'h0, ba});
         chk({tag, " bit"}, {29'h0, err_bit}, {29'h0, bi});
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0]  arr [256];
      logic [7:0]  bad [256];
      logic [23:0] c0, c1;
      int          locs [3][2];
      locs = '{'{0, 0}, '{255, 7}, '{165, 3}};
      rst_n = 1'b0; clr = 0; en = 0; vld = 0; dat = 0;
      stored = 0; calc = 0;
      cnt = 0; exp_word = 0; exp_done = 0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 word", {8'h0, ecc_word}, 32'h0);
      chk("R10 done", {31'h0, ecc_done}, 32'h0);
      chk("R10 code", {8'h0, code_bytes}, 32'h00FF_FFFF);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: single hot bit at address 0, then a hot top bit at address 0
      step("R2", 1'b1, 8'h01, 1'b1, 1'b0);
      feed("R2", 255, 0);
      step("R2", 1'b1, 8'h80, 1'b1, 1'b0);
      feed("R2", 255, 0);
      feed("R2", 256, 1);

      // R1: random bytes with idle gaps, chunks back to back
      for (int i = 0; i < 600; i++) begin
         if (i % 7 == 3) step("R1", 1'b0, 8'($urandom), 1'b1, 1'b0);
         step("R1", 1'b1, 8'($urandom), 1'b1, 1'b0);
      end

      // R3: disabled bytes interleaved
      for (int i = 0; i < 400; i++) begin
         step("R3", 1'b1, 8'($urandom), 1'b0, 1'b0);
         step("R3", 1'b1, 8'($urandom), 1'b1, 1'b0);
      end

      // R4: clear mid-chunk together with a byte, then idle clear
      feed("R4", 100, 2);
      step("R4", 1'b1, 8'hFF, 1'b1, 1'b1);
      feed("R4", 50, 2);
      step("R4", 1'b0, 8'h00, 1'b1, 1'b1);
      feed("R4", 256, 2);
      step("R4", 1'b1, 8'h5A, 1'b1, 1'b1);
      feed("R4", 256, 1);

      // Checking stage
      for (int i = 0; i < 256; i++) arr[i] = 8'($urandom);
      c0 = code_of(ref_of(arr));
      syn_chk("R6 equal", c0, c0, 2'd0, 8'h0, 3'h0);
      syn_chk("R6 ones", 24'hFFFFFF, 24'hFFFFFF, 2'd0, 8'h0, 3'h0);
      for (int n = 0; n < 3; n++) begin
         bad = arr;
         bad[locs[n][0]][locs[n][1]] ^= 1'b1;
         c1 = code_of(ref_of(bad));
         syn_chk("R7 data bit", c0, c1, 2'd1, 8'(locs[n][0]), 3'(locs[n][1]));
      end
      syn_chk("R8 code bit5", c0, c0 ^ 24'h000020, 2'd2, 8'h0, 3'h0);
      syn_chk("R8 code bit23", c0, c0 ^ 24'h800000, 2'd2, 8'h0, 3'h0);
      syn_chk("R8 code bit0", c0, c0 ^ 24'h000001, 2'd2, 8'h0, 3'h0);
      bad = arr;
      bad[3][1] ^= 1'b1;
      bad[200][6] ^= 1'b1;
      syn_chk("R9 two bits", c0, code_of(ref_of(bad)), 2'd3, 8'h0, 3'h0);
      syn_chk("R9 three", c0, c0 ^ 24'h000C10, 2'd3, 8'h0, 3'h0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule